// File: doc/BRIEF.md
# Seconds and Sub-Second Timestamp Counter

This block keeps time of day as a 64-bit timestamp made of two 32-bit words. The low word counts system-clock ticks inside the current second, and the high word counts seconds. At the default 125 MHz clock the low word runs from 0 to 124,999,999. On the following tick it returns to zero, and the seconds word steps by one in that same cycle. The number of ticks per second is a parameter, so a bench or a different clock can use a shorter second.

Software uses a small word-addressed register port. It can load the seconds value, which also restarts the sub-second count, and it can read both words. Reads of the two words are coherent. Reading the tick word stores the matching seconds value in a shadow register, and a later read of the seconds word returns that stored value.

Other blocks, such as an acquisition controller, can take a coherent 64-bit snapshot through a one-cycle capture strobe. The snapshot stays on its output until the next strobe.

Top module: `ts_timestamp`

## Requirements
- R1: After synchronous active-low reset, the tick count, seconds count, seconds-setting register, seconds shadow, read data and snapshot output are all 0.
- R2: When no load occurs and the tick count is below TICKS_PER_SEC-1, the tick count rises by exactly one on each clock edge. Its value never exceeds TICKS_PER_SEC-1.
- R3: When the tick count is TICKS_PER_SEC-1 and no load occurs, the next edge sets the tick count to 0 and adds one to the seconds count.
- R4: A write to word offset 0x0080 (seconds-setting register) loads the written value into the seconds count and clears the tick count to 0 on that edge. A read of 0x0080 returns the last value written there.
- R5: A read of word offset 0x0081 returns, one cycle later on `reg_rdata`, the tick count present at the read edge. The same edge stores the seconds count into the shadow register.
- R6: A read of word offset 0x0082 returns the shadow value taken by the most recent read of 0x0081, not the live seconds count.
- R7: A high `cap_stb` copies {seconds, ticks} into `cap_ts`, with the seconds in bits [63:32] and the ticks in bits [31:0]. The output is visible the cycle after the strobe and holds until the next strobe.
- R8: The seconds count wraps from 0xFFFFFFFF to 0 at a second boundary with no other effect.
- R9: Writes to 0x0081, 0x0082 or any unmapped offset change nothing. Reads of unmapped offsets return 0.
- R10: A seconds load issued on the same cycle as a second rollover takes priority: the seconds count becomes the written value, not that value plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | ADDR_W | Word offset of the register access |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_wdata | input | WORD_W | Write data |
| reg_rd | input | 1 | Read strobe, one cycle |
| reg_rdata | output | WORD_W | Read data, valid the cycle after `reg_rd`, held until the next read |
| cap_stb | input | 1 | Snapshot strobe |
| cap_ts | output | 2*WORD_W | Snapshot {seconds, ticks} |

## Verification
The counter is tried in four settings:
- Free running across several second boundaries. This separates a correct rollover from an off-by-one terminal count.
- Loaded with ordinary values, with the all-ones seconds value, and on the exact rollover cycle. These show whether the load clears the ticks, whether the seconds wrap, and whether load beats increment.

Reads of the tick word and the seconds word are separated by a second boundary. A live read would then differ from a shadowed one. Back-to-back captures, and captures straddling the boundary, show the step and the carry into seconds directly on the snapshot port.

// File: rtl/ts_pkg.sv
// Shared types for the timestamp counter.
// Assumes: register decoding maps each access to one of four targets.
package ts_pkg;

    // Target of a register access after address decode.
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_SET  = 2'd1,
        SEL_LO   = 2'd2,
        SEL_HI   = 2'd3
    } ts_sel_e;

endpackage

// File: rtl/ts_subsec_counter.sv
// Sub-second tick counter: counts 0..TICKS-1 and flags the last tick.
// Assumes: 2 <= TICKS and TICKS-1 fits in W bits; clear beats rollover.
module ts_subsec_counter #(
    parameter int TICKS = 125_000_000,
    parameter int W     = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    output logic [W-1:0] tick,
    output logic         wrap
);
    localparam logic [W-1:0] LAST = W'(TICKS - 1);

    // A wrap happens only when the count ends naturally, not on a clear.
    assign wrap = !clear && (tick == LAST);

    // Advance the tick count, returning to zero on clear or at the end of a second.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick <= '0;
        end else if (clear || wrap) begin
            tick <= '0;
        end else begin
            tick <= tick + W'(1);
        end
    end
endmodule

// File: rtl/ts_sec_counter.sv
// Seconds counter: loads from software or steps by one at each second boundary.
// Assumes: load has priority over incr; the count wraps modulo 2**W.
module ts_sec_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         incr,
    output logic [W-1:0] sec
);
    // Hold, load or increment the seconds count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec <= '0;
        end else if (load) begin
            sec <= load_val;
        end else if (incr) begin
            sec <= sec + W'(1);
        end
    end
endmodule

// File: rtl/ts_reg_port.sv
// Register port: decodes word offsets, keeps the seconds-setting register,
// shadows the seconds word on tick-word reads and returns registered read data.
// Assumes: reg_rd and reg_wr are single-cycle strobes; read latency is one cycle.
module ts_reg_port
    import ts_pkg::*;
#(
    parameter int              AW      = 16,
    parameter int              W       = 32,
    parameter logic [AW-1:0]   SET_OFS = AW'('h0080),
    parameter logic [AW-1:0]   LO_OFS  = AW'('h0081),
    parameter logic [AW-1:0]   HI_OFS  = AW'('h0082)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          wr,
    input  logic [W-1:0]  wdata,
    input  logic          rd,
    input  logic [W-1:0]  tick,
    input  logic [W-1:0]  sec,
    output logic          load,
    output logic [W-1:0]  load_val,
    output logic          rd_lo,
    output logic          rd_hi,
    output logic [W-1:0]  shadow,
    output logic [W-1:0]  rdata
);
    ts_sel_e       sel;
    logic [W-1:0]  set_q;

    // Map the word offset to a register target.
    always_comb begin
        if (addr == SET_OFS) begin
            sel = SEL_SET;
        end else if (addr == LO_OFS) begin
            sel = SEL_LO;
        end else if (addr == HI_OFS) begin
            sel = SEL_HI;
        end else begin
            sel = SEL_NONE;
        end
    end

    assign load     = wr && (sel == SEL_SET);
    assign load_val = wdata;
    assign rd_lo    = rd && (sel == SEL_LO);
    assign rd_hi    = rd && (sel == SEL_HI);

    // Keep the last value written to the seconds-setting register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            set_q <= '0;
        end else if (load) begin
            set_q <= wdata;
        end
    end

    // Store the seconds word whenever the tick word is read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= '0;
        end else if (rd_lo) begin
            shadow <= sec;
        end
    end

    // Register the read data for the addressed target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd) begin
            unique case (sel)
                SEL_SET: rdata <= set_q;
                SEL_LO:  rdata <= tick;
                SEL_HI:  rdata <= shadow;
                default: rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/ts_snapshot.sv
// Snapshot register: copies the full timestamp on a strobe and holds it.
// Assumes: the timestamp input is already coherent within the cycle.
module ts_snapshot #(
    parameter int TW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stb,
    input  logic [TW-1:0] ts_in,
    output logic [TW-1:0] ts_out
);
    // Latch the timestamp on a strobe, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts_out <= '0;
        end else if (stb) begin
            ts_out <= ts_in;
        end
    end
endmodule

// File: rtl/ts_timestamp.sv
// Top level: seconds plus sub-second timestamp with register port and snapshot.
// Assumes: a single clock domain; TICKS_PER_SEC matches the clock frequency.
module ts_timestamp #(
    parameter int                TICKS_PER_SEC = 125_000_000,
    parameter int                WORD_W        = 32,
    parameter int                ADDR_W        = 16,
    parameter logic [ADDR_W-1:0] SET_OFS       = ADDR_W'('h0080),
    parameter logic [ADDR_W-1:0] LO_OFS        = ADDR_W'('h0081),
    parameter logic [ADDR_W-1:0] HI_OFS        = ADDR_W'('h0082)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic                  reg_wr,
    input  logic [WORD_W-1:0]     reg_wdata,
    input  logic                  reg_rd,
    output logic [WORD_W-1:0]     reg_rdata,
    input  logic                  cap_stb,
    output logic [2*WORD_W-1:0]   cap_ts
);
    localparam int TS_W = 2 * WORD_W;

    logic [WORD_W-1:0] tick_cnt;
    logic [WORD_W-1:0] sec_cnt;
    logic [WORD_W-1:0] sec_load_val;
    logic [WORD_W-1:0] hi_shadow;
    logic              sec_load;
    logic              sec_wrap;
    logic              rd_lo;
    logic              rd_hi;

    ts_subsec_counter #(
        .TICKS (TICKS_PER_SEC),
        .W     (WORD_W)
    ) u_subsec (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (sec_load),
        .tick  (tick_cnt),
        .wrap  (sec_wrap)
    );

    ts_sec_counter #(
        .W (WORD_W)
    ) u_sec (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sec_load),
        .load_val (sec_load_val),
        .incr     (sec_wrap),
        .sec      (sec_cnt)
    );

    ts_reg_port #(
        .AW      (ADDR_W),
        .W       (WORD_W),
        .SET_OFS (SET_OFS),
        .LO_OFS  (LO_OFS),
        .HI_OFS  (HI_OFS)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (reg_addr),
        .wr       (reg_wr),
        .wdata    (reg_wdata),
        .rd       (reg_rd),
        .tick     (tick_cnt),
        .sec      (sec_cnt),
        .load     (sec_load),
        .load_val (sec_load_val),
        .rd_lo    (rd_lo),
        .rd_hi    (rd_hi),
        .shadow   (hi_shadow),
        .rdata    (reg_rdata)
    );

    ts_snapshot #(
        .TW (TS_W)
    ) u_snap (
        .clk    (clk),
        .rst_n  (rst_n),
        .stb    (cap_stb),
        .ts_in  ({sec_cnt, tick_cnt}),
        .ts_out (cap_ts)
    );
endmodule

// File: rtl/ts_timestamp_chk.sv
// Checker for ts_timestamp: counting, rollover, load, shadowing and snapshot rules.
// Assumes: bound into ts_timestamp, sampled on the rising clock edge.
module ts_timestamp_chk #(
    parameter int TICKS = 125_000_000,
    parameter int W     = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic [W-1:0]   tick,
    input logic [W-1:0]   sec,
    input logic           load,
    input logic [W-1:0]   load_val,
    input logic           rd_lo,
    input logic           rd_hi,
    input logic [W-1:0]   shadow,
    input logic [W-1:0]   rdata,
    input logic           cap,
    input logic [2*W-1:0] snap
);
    localparam logic [W-1:0] LAST = W'(TICKS - 1);

    assert_tick_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick <= LAST);

    assert_tick_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && tick != LAST) |=> tick == $past(tick) + W'(1));

    assert_rollover_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && tick == LAST) |=> (tick == '0 && sec == $past(sec) + W'(1)));

    // Also covers R10: a load on the rollover cycle yields the loaded value.
    assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (tick == '0 && sec == $past(load_val)));

    assert_shadow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lo |=> (shadow == $past(sec) && rdata == $past(tick)));

    assert_high_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hi |=> rdata == $past(shadow));

    assert_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> snap == {$past(sec), $past(tick)});

    assert_snap_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cap |=> $stable(snap));
endmodule

bind ts_timestamp ts_timestamp_chk #(
    .TICKS (TICKS_PER_SEC),
    .W     (WORD_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_cnt),
    .sec      (sec_cnt),
    .load     (sec_load),
    .load_val (sec_load_val),
    .rd_lo    (rd_lo),
    .rd_hi    (rd_hi),
    .shadow   (hi_shadow),
    .rdata    (reg_rdata),
    .cap      (cap_stb),
    .snap     (cap_ts)
);

// File: tb/ts_timestamp_tb.sv
// Bench for ts_timestamp with a ten-tick second: a vector table, then directed cases.
module ts_timestamp_tb;
    localparam int          T      = 10;
    localparam logic [15:0] A_SET  = 16'h0080;
    localparam logic [15:0] A_LO   = 16'h0081;
    localparam logic [15:0] A_HI   = 16'h0082;
    localparam logic [1:0]  OP_IDL = 2'd0;
    localparam logic [1:0]  OP_WR  = 2'd1;
    localparam logic [1:0]  OP_RD  = 2'd2;
    localparam logic [1:0]  OP_CAP = 2'd3;

    typedef struct packed {
        logic [1:0]  op;
        logic [15:0] addr;
        logic [31:0] data;
        logic [7:0]  gap;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{OP_RD,  A_LO,     32'h0,        8'd0},
        '{OP_RD,  A_HI,     32'h0,        8'd0},
        '{OP_CAP, 16'h0,    32'h0,        8'd3},
        '{OP_RD,  A_SET,    32'h0,        8'd0},
        '{OP_WR,  A_SET,    32'h5,        8'd0},
        '{OP_RD,  A_SET,    32'h0,        8'd0},
        '{OP_RD,  A_LO,     32'h0,        8'd12},
        '{OP_RD,  A_HI,     32'h0,        8'd0},
        '{OP_RD,  A_LO,     32'h0,        8'd0},
        '{OP_RD,  A_HI,     32'h0,        8'd0},
        '{OP_WR,  A_LO,     32'hDEAD,     8'd0},
        '{OP_RD,  A_LO,     32'h0,        8'd0},
        '{OP_WR,  A_HI,     32'h1234,     8'd0},
        '{OP_CAP, 16'h0,    32'h0,        8'd0},
        '{OP_WR,  16'h0083, 32'h9999,     8'd0},
        '{OP_RD,  16'h0083, 32'h0,        8'd0},
        '{OP_CAP, 16'h0,    32'h0,        8'd7}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] reg_addr;
    logic        reg_wr;
    logic [31:0] reg_wdata;
    logic        reg_rd;
    logic [31:0] reg_rdata;
    logic        cap_stb;
    logic [63:0] cap_ts;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    // Reference model built from the requirements.
    logic [31:0] m_tick, m_sec, m_set, m_shadow, m_rdata;
    logic [63:0] m_snap;

    always #5 clk = ~clk;

    ts_timestamp #(.TICKS_PER_SEC(T)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rd    (reg_rd),
        .reg_rdata (reg_rdata),
        .cap_stb   (cap_stb),
        .cap_ts    (cap_ts)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_tick <= 0; m_sec <= 0; m_set <= 0; m_shadow <= 0; m_rdata <= 0; m_snap <= 0;
        end else begin
            if (reg_wr && reg_addr == A_SET) begin
                m_sec <= reg_wdata; m_tick <= 0; m_set <= reg_wdata;
            end else if (m_tick == T - 1) begin
                m_tick <= 0; m_sec <= m_sec + 1;
            end else begin
                m_tick <= m_tick + 1;
            end
            if (reg_rd) begin
                if (reg_addr == A_SET) m_rdata <= m_set;
                else if (reg_addr == A_LO) begin m_rdata <= m_tick; m_shadow <= m_sec; end
                else if (reg_addr == A_HI) m_rdata <= m_shadow;
                else m_rdata <= 0;
            end
            if (cap_stb) m_snap <= {m_sec, m_tick};
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 50000 && !done) begin
            done = 1'b1;
            n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one operation at a falling edge; return at the next falling edge.
    task automatic apply(input logic [1:0] op, input logic [15:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = (op == OP_WR);
        reg_rd    = (op == OP_RD);
        cap_stb   = (op == OP_CAP);
        @(negedge clk);
        reg_wr  = 1'b0;
        reg_rd  = 1'b0;
        cap_stb = 1'b0;
    endtask

    task automatic wait_last_tick();
        while (m_tick != T - 1) @(negedge clk);
    endtask

    function automatic string tag_of(input logic [1:0] op, input logic [15:0] a);
        if (op == OP_CAP) return "R7";
        if (op == OP_WR) return (a == A_SET) ? "R4" : "R9";
        if (a == A_SET) return "R4";
        if (a == A_LO) return "R5";
        if (a == A_HI) return "R6";
        return "R9";
    endfunction

    initial begin
        rst_n = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0; reg_rd = 1'b0; cap_stb = 1'b0;
        repeat (3) @(negedge clk);
        // R1: outputs cleared while in reset.
        check("R1", {32'h0, reg_rdata}, 64'h0);
        check("R1", cap_ts, 64'h0);
        rst_n = 1'b1;
        apply(OP_RD, A_LO, 32'h0);
        check("R1", {32'h0, reg_rdata}, 64'h0);
        apply(OP_RD, A_SET, 32'h0);
        check("R1", {32'h0, reg_rdata}, 64'h0);

        // Vector table walk against the model.
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].op != OP_IDL) begin
                apply(VECS[i].op, VECS[i].addr, VECS[i].data);
                check(tag_of(VECS[i].op, VECS[i].addr), {32'h0, reg_rdata}, {32'h0, m_rdata});
                check(tag_of(VECS[i].op, VECS[i].addr), cap_ts, m_snap);
            end
            repeat (int'(VECS[i].gap)) @(negedge clk);
        end

        // R4 then R2: load, then two back-to-back captures.
        apply(OP_WR, A_SET, 32'd100);
        apply(OP_CAP, 16'h0, 32'h0);
        check("R4", cap_ts, {32'd100, 32'd0});
        apply(OP_CAP, 16'h0, 32'h0);
        check("R2", cap_ts, {32'd100, 32'd1});

        // R3: captures on both sides of a second boundary.
        wait_last_tick();
        apply(OP_CAP, 16'h0, 32'h0);
        check("R3", cap_ts, {32'd100, 32'd9});
        apply(OP_CAP, 16'h0, 32'h0);
        check("R3", cap_ts, {32'd101, 32'd0});

        // R7: the snapshot holds with no strobe.
        repeat (5) @(negedge clk);
        check("R7", cap_ts, {32'd101, 32'd0});

        // R10: load on the rollover cycle wins over the increment.
        wait_last_tick();
        apply(OP_WR, A_SET, 32'h77);
        apply(OP_CAP, 16'h0, 32'h0);
        check("R10", cap_ts, {32'h77, 32'd0});

        // R8: seconds wrap from all ones to zero.
        apply(OP_WR, A_SET, 32'hFFFF_FFFF);
        wait_last_tick();
        apply(OP_CAP, 16'h0, 32'h0);
        check("R8", cap_ts, {32'hFFFF_FFFF, 32'd9});
        apply(OP_CAP, 16'h0, 32'h0);
        check("R8", cap_ts, {32'h0, 32'd0});

        // R5 and R6: shadowed seconds survive a later second boundary.
        apply(OP_WR, A_SET, 32'd3);
        apply(OP_RD, A_LO, 32'h0);
        check("R5", {32'h0, reg_rdata}, 64'h0);
        repeat (12) @(negedge clk);
        apply(OP_RD, A_HI, 32'h0);
        check("R6", {32'h0, reg_rdata}, {32'h0, 32'd3});

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule